// File: doc/BRIEF.md
# Stereo Audio Transmit Queue Controller

This block buffers stereo audio samples on their way from a host to a serial audio transmitter. A small queue of entries, each pairing a left-channel and a right-channel sample, is filled through a host write port and emptied by read requests from the serializer. A state machine gates every read. Reads are refused until the queue has been filled completely after a start, and again after any total drain. Clearing the run control while samples remain lets the stored samples drain out before the block goes idle.

The host sets `run_i` to start transmission and preloads the queue. The serializer raises `rd_req_i` whenever it needs the next stereo pair. It takes the pair in the same cycle, but only when `rd_valid_o` is high. The state code, the full flag and the empty flag can be read by software.

Top module: `aud_txq`

## Requirements
- R1: After reset the state code is 0 (STOP), the full flag is 0, the empty flag is 1, and `rd_valid_o` is 0.
- R2: The state code takes only the values STOP=0, INIT=1, FULL=2, LACK=3, EMPTY=4 and FLUSH=5. The values 6 and 7 never appear.
- R3: With `run_i` high in STOP, the state becomes INIT at the next clock edge. In STOP and INIT a read request never produces `rd_valid_o`.
- R4: In INIT the state changes to FULL on the edge that stores the fourth entry, and read requests are then served.
- R5: A served read raises `rd_valid_o` in the same cycle as `rd_req_i` and presents the oldest entry. Left and right samples stay paired, and entries leave in the order they were written.
- R6: While running after a fill, a queue holding one to three entries is in LACK (3).
- R7: A read that takes the last entry moves the state to EMPTY (4). In EMPTY, reads are refused and partial refills keep the state at EMPTY. The edge that stores the fourth entry moves the state to FULL.
- R8: Clearing `run_i` while entries remain moves the state to FLUSH (5). In FLUSH, reads are served, and the read that takes the last entry moves the state to STOP.
- R9: Setting `run_i` during FLUSH moves the state to FULL when four entries are held and to LACK otherwise.
- R10: Clearing `run_i` while the queue is empty moves the state directly to STOP.
- R11: The full flag is 1 exactly when four entries are held and clears after a read. The empty flag is 1 exactly when no entry is held. Both flags are updated at the edge that changes the fill level.
- R12: A write to a full queue is ignored. The flags do not change, and the stored entries are read out unchanged, with no extra entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Start (1) / stop (0) control |
| wr_en_i | input | 1 | Host write strobe |
| wr_left_i | input | 16 | Left sample to store |
| wr_right_i | input | 16 | Right sample to store |
| rd_req_i | input | 1 | Serializer read request |
| rd_valid_o | output | 1 | Read served this cycle |
| rd_left_o | output | 16 | Left sample of the oldest entry |
| rd_right_o | output | 16 | Right sample of the oldest entry |
| state_o | output | 3 | Controller state code |
| full_o | output | 1 | Queue full flag |
| empty_o | output | 1 | Queue empty flag |

## Verification
The read data and `rd_valid_o` are combinational, so the bench checks them in the same cycle as the request, after the request has settled and before the next rising edge. The state code and both flags come from registers that are updated at the edge that takes the write, the read or the `run_i` change. The bench drives every stimulus on a falling edge and checks these outputs at the next falling edge, one edge later. Each entry carries a distinct left/right pair, so lost entries, reordered entries and entries that were written in error all show up as data mismatches.

// File: rtl/aud_txq_pkg.sv
package aud_txq_pkg;

    typedef enum logic [2:0] {
        ST_STOP  = 3'd0,
        ST_INIT  = 3'd1,
        ST_FULL  = 3'd2,
        ST_LACK  = 3'd3,
        ST_EMPTY = 3'd4,
        ST_FLUSH = 3'd5
    } txq_state_e;

    // States in which the serializer may take entries
    function automatic logic may_drain(txq_state_e s);
        return (s == ST_FULL) || (s == ST_LACK) || (s == ST_FLUSH);
    endfunction

endpackage

// File: rtl/aud_txq_store.sv
module aud_txq_store #(
    parameter int DEPTH = 4,
    parameter int SW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [SW-1:0] wr_left,
    input  logic [SW-1:0] wr_right,
    output logic [SW-1:0] rd_left,
    output logic [SW-1:0] rd_right
);
    localparam int PW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int ENTRY_W = 2 * SW;

    typedef struct packed {
        logic [DEPTH-1:0][ENTRY_W-1:0] mem;
        logic [PW-1:0]                 wp;
        logic [PW-1:0]                 rp;
    } store_t;

    store_t st_d, st_q;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wp] = {wr_left, wr_right};
            st_d.wp           = bump(st_q.wp);
        end
        if (pop) begin
            st_d.rp = bump(st_q.rp);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign {rd_left, rd_right} = st_q.mem[st_q.rp];

endmodule

// File: rtl/aud_txq_level.sv
module aud_txq_level #(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [CW-1:0] cnt_d,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          full;
        logic          empty;
    } lvl_t;

    lvl_t lv_d, lv_q;

    always_comb begin
        lv_d = lv_q;
        case ({push, pop})
            2'b10:   lv_d.cnt = lv_q.cnt + 1'b1;
            2'b01:   lv_d.cnt = lv_q.cnt - 1'b1;
            default: lv_d.cnt = lv_q.cnt;
        endcase
        lv_d.full  = (lv_d.cnt == CW'(DEPTH));
        lv_d.empty = (lv_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lv_q <= '{cnt: '0, full: 1'b0, empty: 1'b1};
        else        lv_q <= lv_d;
    end

    assign cnt_d = lv_d.cnt;
    assign full  = lv_q.full;
    assign empty = lv_q.empty;

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lv_q.cnt <= CW'(DEPTH));

    // R12
    full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lv_q.full |-> !push);

endmodule

// File: rtl/aud_txq_fsm.sv
module aud_txq_fsm
    import aud_txq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] cnt_d,
    output txq_state_e    state
);
    typedef struct packed {
        txq_state_e st;
    } fsm_t;

    fsm_t fs_d, fs_q;
    logic will_full, will_empty;

    always_comb begin
        will_full  = (cnt_d == CW'(DEPTH));
        will_empty = (cnt_d == '0);
        fs_d = fs_q;
        unique case (fs_q.st)
            ST_STOP: begin
                if (run) fs_d.st = ST_INIT;
            end
            ST_INIT, ST_EMPTY: begin
                if (!run)           fs_d.st = will_empty ? ST_STOP : ST_FLUSH;
                else if (will_full) fs_d.st = ST_FULL;
            end
            ST_FULL, ST_LACK: begin
                if (!run)            fs_d.st = will_empty ? ST_STOP : ST_FLUSH;
                else if (will_empty) fs_d.st = ST_EMPTY;
                else if (will_full)  fs_d.st = ST_FULL;
                else                 fs_d.st = ST_LACK;
            end
            ST_FLUSH: begin
                if (run) begin
                    if (will_full)       fs_d.st = ST_FULL;
                    else if (will_empty) fs_d.st = ST_EMPTY;
                    else                 fs_d.st = ST_LACK;
                end else if (will_empty) begin
                    fs_d.st = ST_STOP;
                end
            end
            default: fs_d.st = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= '{st: ST_STOP};
        else        fs_q <= fs_d;
    end

    assign state = fs_q.st;

    // R2
    state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_q.st inside {ST_STOP, ST_INIT, ST_FULL, ST_LACK, ST_EMPTY, ST_FLUSH});

endmodule

// File: rtl/aud_txq.sv
module aud_txq
    import aud_txq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int SW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          wr_en_i,
    input  logic [SW-1:0] wr_left_i,
    input  logic [SW-1:0] wr_right_i,
    input  logic          rd_req_i,
    output logic          rd_valid_o,
    output logic [SW-1:0] rd_left_o,
    output logic [SW-1:0] rd_right_o,
    output logic [2:0]    state_o,
    output logic          full_o,
    output logic          empty_o
);
    localparam int CW = $clog2(DEPTH + 1);

    txq_state_e    state;
    logic [CW-1:0] cnt_d;
    logic          full, empty;
    logic          push, pop;

    always_comb begin
        push = wr_en_i && !full;
        pop  = rd_req_i && !empty && may_drain(state);
    end

    aud_txq_store #(.DEPTH(DEPTH), .SW(SW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .wr_left  (wr_left_i),
        .wr_right (wr_right_i),
        .rd_left  (rd_left_o),
        .rd_right (rd_right_o)
    );

    aud_txq_level #(.DEPTH(DEPTH)) u_level (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .cnt_d (cnt_d),
        .full  (full),
        .empty (empty)
    );

    aud_txq_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_i),
        .cnt_d (cnt_d),
        .state (state)
    );

    assign rd_valid_o = pop;
    assign state_o    = state;
    assign full_o     = full;
    assign empty_o    = empty;

    // R3
    no_early_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 || state_o == 3'd1) |-> !rd_valid_o);

    // R3
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && run_i) |=> (state_o == 3'd1));

    // R11
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));

    // R12
    full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && wr_en_i && !rd_valid_o) |=> full_o);

    // R10
    stop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 3'd0 && !run_i && empty_o && !wr_en_i) |=> (state_o == 3'd0));

endmodule

// File: tb/aud_txq_bench.sv
module aud_txq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_left_i = '0;
    logic [15:0] wr_right_i = '0;
    logic        rd_req_i = 1'b0;
    logic        rd_valid_o;
    logic [15:0] rd_left_o, rd_right_o;
    logic [2:0]  state_o;
    logic        full_o, empty_o;

    int checks = 0;
    int errors = 0;
    int bad_codes = 0;

    always #2 clk = ~clk;

    aud_txq u_aud_txq (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .wr_en_i(wr_en_i),
        .wr_left_i(wr_left_i), .wr_right_i(wr_right_i), .rd_req_i(rd_req_i),
        .rd_valid_o(rd_valid_o), .rd_left_o(rd_left_o), .rd_right_o(rd_right_o),
        .state_o(state_o), .full_o(full_o), .empty_o(empty_o)
    );

    // R2 monitor: reserved codes
    always @(negedge clk) if (rst_n && state_o > 3'd5) bad_codes++;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put(logic [15:0] l, logic [15:0] r);
        wr_en_i = 1'b1; wr_left_i = l; wr_right_i = r;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic take(string req, logic [15:0] l, logic [15:0] r);
        rd_req_i = 1'b1;
        #1;
        chk(req, int'(rd_valid_o), 1);
        chk(req, int'(rd_left_o), int'(l));
        chk(req, int'(rd_right_o), int'(r));
        tick();
        rd_req_i = 1'b0;
    endtask

    task automatic refused(string req);
        rd_req_i = 1'b1;
        #1;
        chk(req, int'(rd_valid_o), 0);
        tick();
        rd_req_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", int'(state_o), 0);
        chk("R1", int'(full_o), 0);
        chk("R1", int'(empty_o), 1);
        chk("R1", int'(rd_valid_o), 0);
    endtask

    task automatic t_start_fill();
        refused("R3");               // STOP refuses reads
        run_i = 1'b1;
        tick();
        chk("R3", int'(state_o), 1);
        refused("R3");               // INIT, empty
        for (int i = 0; i < 3; i++) put(16'h1000 + 16'(i), 16'h2000 + 16'(i));
        chk("R4", int'(state_o), 1);
        chk("R11", int'(empty_o), 0);
        chk("R11", int'(full_o), 0);
        refused("R3");               // INIT with data
        chk("R3", int'(state_o), 1);
        put(16'h1003, 16'h2003);
        chk("R4", int'(state_o), 2);
        chk("R11", int'(full_o), 1);
    endtask

    task automatic t_full_write();
        put(16'hDEAD, 16'hBEEF);
        chk("R12", int'(state_o), 2);
        chk("R12", int'(full_o), 1);
        chk("R12", int'(empty_o), 0);
    endtask

    task automatic t_drain();
        take("R5", 16'h1000, 16'h2000);
        chk("R6", int'(state_o), 3);
        chk("R11", int'(full_o), 0);
        take("R5", 16'h1001, 16'h2001);
        chk("R6", int'(state_o), 3);
        take("R5", 16'h1002, 16'h2002);
        take("R12", 16'h1003, 16'h2003);
        chk("R7", int'(state_o), 4);
        chk("R11", int'(empty_o), 1);
        refused("R12");              // no stray entry from full write
    endtask

    task automatic t_refill();
        put(16'h3000, 16'h4000);
        put(16'h3001, 16'h4001);
        chk("R7", int'(state_o), 4);
        refused("R7");
        chk("R7", int'(state_o), 4);
        put(16'h3002, 16'h4002);
        put(16'h3003, 16'h4003);
        chk("R7", int'(state_o), 2);
    endtask

    task automatic t_flush();
        take("R5", 16'h3000, 16'h4000);
        chk("R6", int'(state_o), 3);
        run_i = 1'b0;
        tick();
        chk("R8", int'(state_o), 5);
        run_i = 1'b1;
        tick();
        chk("R9", int'(state_o), 3);
        put(16'h3004, 16'h4004);
        chk("R6", int'(state_o), 2);
        run_i = 1'b0;
        tick();
        chk("R8", int'(state_o), 5);
        run_i = 1'b1;
        tick();
        chk("R9", int'(state_o), 2);
        run_i = 1'b0;
        tick();
        chk("R8", int'(state_o), 5);
        take("R8", 16'h3001, 16'h4001);
        take("R8", 16'h3002, 16'h4002);
        take("R8", 16'h3003, 16'h4003);
        chk("R8", int'(state_o), 5);
        take("R8", 16'h3004, 16'h4004);
        chk("R8", int'(state_o), 0);
        chk("R11", int'(empty_o), 1);
    endtask

    task automatic t_stop_empty();
        run_i = 1'b1;
        tick();
        chk("R3", int'(state_o), 1);
        run_i = 1'b0;
        tick();
        chk("R10", int'(state_o), 0);
        run_i = 1'b1;
        tick();
        for (int i = 0; i < 4; i++) put(16'h5000 + 16'(i), 16'h6000 + 16'(i));
        chk("R4", int'(state_o), 2);
        for (int i = 0; i < 4; i++) take("R5", 16'h5000 + 16'(i), 16'h6000 + 16'(i));
        chk("R7", int'(state_o), 4);
        run_i = 1'b0;
        tick();
        chk("R10", int'(state_o), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_start_fill();
        t_full_write();
        t_drain();
        t_refill();
        t_flush();
        t_stop_empty();
        chk("R2", bad_codes, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule